// File: doc/BRIEF.md
# Round-Robin Memory Copy Engine

This block is a four-channel memory-to-memory copy engine. Software programs a channel with a source address, a destination address and a byte count, then sets the channel's run bit. A scheduler steps a pointer through the channels in a fixed rotating order. Each step is one service slot. In that slot the engine serves at most one burst of up to 2048 bytes for the visited channel. A channel therefore never holds the memory port for longer than one burst while other channels are waiting.

Every channel has a completion flag and an error flag, and their OR drives a single interrupt line. Each flag is cleared by writing one to it. For testing error paths, each channel has a countdown that can force it to abort with an error after a chosen number of visits.

The register port is a single-cycle write strobe with a combinational read path. The memory port has separate read and write strobes. A read returns its data one clock later, and the engine writes that data to the destination in the following cycle, so it moves one word per clock.

Top module: `rr_dma_engine`

## Requirements
- R1: Register address map (6-bit address). With bit 5 clear, bits 4:3 select the channel and bits 2:0 select the field: 0 = source, 1 = destination, 2 = byte count, 3 = control, 4 = fail countdown. With bit 5 set, bit 0 selects the flag register: 0 = completion, 1 = error, with one bit per channel. Every register and the interrupt read zero after reset.
- R2: The service pointer visits channels 0,1,2,3 and then wraps to 0. It moves exactly once per slot, and a slot that visits a stopped channel lasts one cycle and moves no data. With two channels running, bursts alternate between them.
- R3: A slot on a running channel with a nonzero count moves min(count, 0x800) bytes. At the end of the slot it subtracts that amount from the count and adds it to both addresses.
- R4: The memory port moves whole 32-bit words. A count that is not a multiple of 4 is rounded up to the next word. Each write to the destination follows one cycle after the matching source read, and no memory access happens in the slot's decision cycle.
- R5: A running channel visited with a zero count clears its run bit and sets its completion flag.
- R6: The fail countdown is decremented on each visit while the channel is running and the countdown is nonzero. On the visit where it reaches zero, the run bit clears, the error flag sets, and neither data nor the count changes.
- R7: Control bit 31 is the run bit. Writing 1 starts the channel, writing 0 stops it, and reading bit 31 back as 0 means idle. A burst already in progress finishes and updates the count, but no completion flag is raised afterwards.
- R8: Writes to the source, destination, count and fail countdown of a running channel are ignored.
- R9: Writing 1 to a flag bit clears that bit, and writing 0 leaves a flag bit unchanged. The interrupt output is high exactly while any flag bit is set.
- R10: The largest count, 0x1FFF, copies 2048 words and writes nothing beyond them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_raddr_o | output | 32 | Memory read byte address, word aligned |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | 32 | Memory write byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| irq_o | output | 1 | OR of all completion and error flags |

## Verification
Directed copies use a 100-byte count, a 6-byte count and the 0x1FFF maximum. Together they separate a short single burst, word rounding and the multi-burst boundary that ends with a partial burst. Seeded random copies vary the channel, the count and both offsets, which exposes address or count arithmetic that only fails for some sizes. Fail countdowns of 1 and 3 show that the abort happens on the right visit and that no burst is moved in that slot. A stop issued mid-burst, together with writes to a busy channel, shows the effect of the run bit. Two channels running at once produce a burst owner sequence that separates rotation from one channel finishing before the other starts.

// File: rtl/rr_dma_pkg.sv
package rr_dma_pkg;
  typedef enum logic [2:0] {
    FLD_SRC  = 3'd0,
    FLD_DST  = 3'd1,
    FLD_CNT  = 3'd2,
    FLD_CTRL = 3'd3,
    FLD_FAIL = 3'd4
  } fld_e;

  typedef enum logic {
    ST_PICK = 1'b0,
    ST_MOVE = 1'b1
  } sched_e;

  localparam int unsigned RUN_BIT = 31;
endpackage

// File: rtl/rr_dma_chan.sv
module rr_dma_chan
  import rr_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned FAIL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  fld_e              fld_i,
  input  logic [31:0]       wdata_i,
  input  logic              clr_run_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  adv_bytes_i,
  input  logic              dec_fail_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [FAIL_W-1:0] fail_o,
  output logic              run_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FAIL_W-1:0] fail_q;
  logic              run_q;
  logic              cfg_wr;

  // configuration is frozen while the channel runs
  assign cfg_wr = wr_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      fail_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (clr_run_i) run_q <= 1'b0;
      else if (wr_i && fld_i == FLD_CTRL) run_q <= wdata_i[RUN_BIT];

      // engine update wins over a late software write
      if (adv_i) begin
        src_q <= src_q + ADDR_W'(adv_bytes_i);
        dst_q <= dst_q + ADDR_W'(adv_bytes_i);
        cnt_q <= cnt_q - adv_bytes_i;
      end else if (cfg_wr) begin
        case (fld_i)
          FLD_SRC: src_q <= wdata_i[ADDR_W-1:0];
          FLD_DST: dst_q <= wdata_i[ADDR_W-1:0];
          FLD_CNT: cnt_q <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end

      if (dec_fail_i) fail_q <= fail_q - 1'b1;
      else if (cfg_wr && fld_i == FLD_FAIL) fail_q <= wdata_i[FAIL_W-1:0];
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign fail_o = fail_q;
  assign run_o  = run_q;
endmodule

// File: rtl/rr_dma_mover.sv
module rr_dma_mover #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORDS_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  src_i,
  input  logic [ADDR_W-1:0]  dst_i,
  input  logic [WORDS_W-1:0] words_i,
  input  logic [31:0]        rdata_i,
  output logic               re_o,
  output logic [ADDR_W-1:0]  raddr_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  waddr_o,
  output logic [31:0]        wdata_o,
  output logic               done_o
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic               busy_q, wv_q;
  logic [WA_W-1:0]    rd_ptr_q, wr_ptr_q;
  logic [WORDS_W-1:0] left_q;

  assign re_o    = busy_q && (left_q != '0);
  assign raddr_o = {rd_ptr_q, 2'b00};
  assign we_o    = wv_q;
  assign waddr_o = {wr_ptr_q, 2'b00};
  assign wdata_o = rdata_i;
  assign done_o  = wv_q && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      wv_q     <= 1'b0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      left_q   <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      wv_q     <= 1'b0;
      rd_ptr_q <= src_i[ADDR_W-1:2];
      wr_ptr_q <= dst_i[ADDR_W-1:2];
      left_q   <= words_i;
    end else if (busy_q) begin
      if (re_o) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
        left_q   <= left_q - 1'b1;
      end
      if (we_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      wv_q <= re_o;
      if (done_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_dma_engine.sv
module rr_dma_engine
  import rr_dma_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 13,
  parameter int unsigned BURST_BYTES = 2048,
  parameter int unsigned FAIL_W      = 8,
  localparam int unsigned CH_W       = $clog2(NUM_CH),
  localparam int unsigned RA_W       = CH_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              irq_o
);
  localparam int unsigned WORDS_W = $clog2(BURST_BYTES / 4) + 1;
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_BYTES);

  logic [ADDR_W-1:0] src_a  [NUM_CH];
  logic [ADDR_W-1:0] dst_a  [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [FAIL_W-1:0] fail_a [NUM_CH];
  logic [NUM_CH-1:0] run_v;

  sched_e            st_q;
  logic [CH_W-1:0]   ptr_q;
  logic [CNT_W-1:0]  bytes_q;
  logic [NUM_CH-1:0] comp_q, err_q;

  // register decode
  logic            glob;
  logic [CH_W-1:0] dch;
  fld_e            dfld;
  assign glob = reg_addr_i[RA_W-1];
  assign dch  = reg_addr_i[CH_W+2:3];
  assign dfld = fld_e'(reg_addr_i[2:0]);

  // visit decision for the channel under the pointer
  logic              pick, cur_run, fail_hit, fail_dec, fin_hit, go, mv_done, slot_end;
  logic [CNT_W-1:0]  cur_cnt, burst_b;
  logic [FAIL_W-1:0] cur_fail;
  logic [WORDS_W-1:0] burst_w;

  assign pick     = (st_q == ST_PICK);
  assign cur_run  = run_v[ptr_q];
  assign cur_cnt  = cnt_a[ptr_q];
  assign cur_fail = fail_a[ptr_q];
  assign fail_dec = pick && cur_run && (cur_fail != '0);
  assign fail_hit = fail_dec && (cur_fail == FAIL_W'(1));
  assign fin_hit  = pick && cur_run && !fail_hit && (cur_cnt == '0);
  assign go       = pick && cur_run && !fail_hit && (cur_cnt != '0);
  assign burst_b  = (cur_cnt > BURST_C) ? BURST_C : cur_cnt;
  assign burst_w  = WORDS_W'((burst_b + CNT_W'(3)) >> 2);
  assign slot_end = (pick && !go) || (!pick && mv_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PICK;
      ptr_q   <= '0;
      bytes_q <= '0;
    end else begin
      if (go) begin
        st_q    <= ST_MOVE;
        bytes_q <= burst_b;
      end else if (!pick && mv_done) begin
        st_q <= ST_PICK;
      end
      if (slot_end) ptr_q <= (ptr_q == CH_W'(NUM_CH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = (ptr_q == CH_W'(i));
    rr_dma_chan #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W),
      .FAIL_W(FAIL_W)
    ) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i && !glob && (dch == CH_W'(i))),
      .fld_i      (dfld),
      .wdata_i    (reg_wdata_i),
      .clr_run_i  (sel && (fail_hit || fin_hit)),
      .adv_i      (sel && !pick && mv_done),
      .adv_bytes_i(bytes_q),
      .dec_fail_i (sel && fail_dec),
      .src_o      (src_a[i]),
      .dst_o      (dst_a[i]),
      .cnt_o      (cnt_a[i]),
      .fail_o     (fail_a[i]),
      .run_o      (run_v[i])
    );
  end

  rr_dma_mover #(
    .ADDR_W (ADDR_W),
    .WORDS_W(WORDS_W)
  ) i_mover (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go),
    .src_i  (src_a[ptr_q]),
    .dst_i  (dst_a[ptr_q]),
    .words_i(burst_w),
    .rdata_i(mem_rdata_i),
    .re_o   (mem_re_o),
    .raddr_o(mem_raddr_o),
    .we_o   (mem_we_o),
    .waddr_o(mem_waddr_o),
    .wdata_o(mem_wdata_o),
    .done_o (mv_done)
  );

  // flags: set wins over write-one-to-clear
  logic [NUM_CH-1:0] comp_set, err_set, comp_clr, err_clr;
  always_comb begin
    comp_set = '0;
    err_set  = '0;
    if (fin_hit)  comp_set[ptr_q] = 1'b1;
    if (fail_hit) err_set[ptr_q]  = 1'b1;
  end
  assign comp_clr = (reg_we_i && glob && !reg_addr_i[0]) ? reg_wdata_i[NUM_CH-1:0] : '0;
  assign err_clr  = (reg_we_i && glob &&  reg_addr_i[0]) ? reg_wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q <= '0;
      err_q  <= '0;
    end else begin
      comp_q <= (comp_q & ~comp_clr) | comp_set;
      err_q  <= (err_q & ~err_clr) | err_set;
    end
  end

  assign irq_o = |{comp_q, err_q};

  always_comb begin
    reg_rdata_o = '0;
    if (glob) begin
      reg_rdata_o = reg_addr_i[0] ? 32'(err_q) : 32'(comp_q);
    end else begin
      case (dfld)
        FLD_SRC:  reg_rdata_o = 32'(src_a[dch]);
        FLD_DST:  reg_rdata_o = 32'(dst_a[dch]);
        FLD_CNT:  reg_rdata_o = 32'(cnt_a[dch]);
        FLD_CTRL: reg_rdata_o[RUN_BIT] = run_v[dch];
        FLD_FAIL: reg_rdata_o = 32'(fail_a[dch]);
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rr_dma_chk.sv
module rr_dma_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic              irq_o,
  input logic              in_pick,
  input logic [CH_W-1:0]   ptr_q,
  input logic [NUM_CH-1:0] comp_q,
  input logic [NUM_CH-1:0] err_q
);
  logic [NUM_CH-1:0] flags;
  assign flags = comp_q | err_q;

  // R4
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));

  // R4
  no_mem_in_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pick |-> (!mem_re_o && !mem_we_o));

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) |->
      (ptr_q == (($past(ptr_q) == CH_W'(NUM_CH - 1)) ? '0 : $past(ptr_q) + 1'b1)));

  // R5
  one_flag_per_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags & ~$past(flags)) <= 1);

  // R6
  flag_from_visit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags & ~$past(flags)) != '0) |-> $past(in_pick));

  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((flags & ~$past(flags)) != '0));
endmodule

bind rr_dma_engine rr_dma_chk #(
  .NUM_CH(NUM_CH),
  .CH_W  (CH_W)
) i_rr_dma_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mem_re_o(mem_re_o),
  .mem_we_o(mem_we_o),
  .irq_o   (irq_o),
  .in_pick (pick),
  .ptr_q   (ptr_q),
  .comp_q  (comp_q),
  .err_q   (err_q)
);

// File: tb/test_rr_dma_engine.sv
module test_rr_dma_engine;
  localparam int MEM_WORDS = 4096;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_re, mem_we, irq;
  logic [31:0] mem_raddr, mem_waddr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit oob = 1'b0;
  bit log_on = 1'b0;
  int own_log [16];
  int n_own = 0;

  logic [31:0] mem [MEM_WORDS];

  rr_dma_engine i_rr_dma_engine (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we),
    .reg_addr_i (reg_addr),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .mem_re_o   (mem_re),
    .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata),
    .mem_we_o   (mem_we),
    .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata),
    .irq_o      (irq)
  );

  always #10 clk = ~clk;

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_raddr[13:2]];
    if (mem_we) begin
      if (mem_waddr >= 32'h4000) oob = 1'b1;
      else mem[mem_waddr[13:2]] <= mem_wdata;
      if (log_on) begin
        int own;
        own = (mem_waddr >= 32'h3000) ? 2 : 0;
        if ((n_own == 0 || own_log[n_own-1] != own) && n_own < 16) begin
          own_log[n_own] = own;
          n_own++;
        end
      end
    end
  end

  function automatic logic [5:0] ca(int ch, int fld);
    return 6'(ch * 8 + fld);
  endfunction

  function automatic int words_of(int cnt);
    return (cnt + 3) / 4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rrd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_bits(logic [5:0] a, logic [31:0] mask);
    logic [31:0] d;
    for (int k = 0; k < 20000; k++) begin
      rrd(a, d);
      if ((d & mask) == mask) return;
    end
  endtask

  task automatic fill(int src_w, int dst_w, int n);
    for (int k = 0; k < n; k++) begin
      if (src_w + k < MEM_WORDS) mem[src_w + k] = $urandom;
      if (dst_w + k < MEM_WORDS) mem[dst_w + k] = 32'hA5A5_0000 ^ 32'(k);
    end
  endtask

  task automatic start(int ch, int src, int dst, int cnt, int fail);
    rwr(ca(ch, 0), 32'(src));
    rwr(ca(ch, 1), 32'(dst));
    rwr(ca(ch, 2), 32'(cnt));
    rwr(ca(ch, 4), 32'(fail));
    rwr(ca(ch, 3), 32'h8000_0000);
  endtask

  task automatic cmp_copy(string tag, int src, int dst, int cnt);
    int bad = 0;
    int n = words_of(cnt);
    for (int k = 0; k < n; k++)
      if (mem[dst/4 + k] !== mem[src/4 + k]) bad++;
    chk({tag, " words copied"}, 32'(bad), 32'd0);
    if (dst/4 + n < MEM_WORDS)
      chk({tag, " word past end untouched"}, mem[dst/4 + n], 32'hA5A5_0000 ^ 32'(n));
  endtask

  logic [31:0] d;

  initial begin
    void'($urandom(32'h1d5a));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rrd(ca(c, 3), d); chk("R1 ctrl after reset", d, 0);
      rrd(ca(c, 2), d); chk("R1 count after reset", d, 0);
    end
    rrd(6'h20, d); chk("R1 completion after reset", d, 0);
    rrd(6'h21, d); chk("R1 error after reset", d, 0);
    chk("R1 irq after reset", 32'(irq), 0);

    // R3 R5 short copy on channel 0
    fill(0, 32'h800, 32);
    start(0, 0, 32'h2000, 100, 0);
    wait_bits(6'h20, 32'h1);
    cmp_copy("R3", 0, 32'h2000, 100);
    rrd(ca(0, 2), d); chk("R3 count drained", d, 0);
    rrd(ca(0, 0), d); chk("R3 source advanced", d, 100);
    rrd(ca(0, 1), d); chk("R3 destination advanced", d, 32'h2064);
    rrd(ca(0, 3), d); chk("R5 run cleared at completion", d, 0);
    rrd(6'h20, d); chk("R5 completion flag", d, 1);
    chk("R9 irq raised", 32'(irq), 1);
    rwr(6'h20, 32'h0);
    rrd(6'h20, d); chk("R9 writing zero keeps flag", d, 1);
    rwr(6'h20, 32'h1);
    rrd(6'h20, d); chk("R9 flag cleared by one", d, 0);
    chk("R9 irq low after clear", 32'(irq), 0);

    // R4 word rounding
    fill(32'h40, 32'h840, 4);
    start(1, 32'h100, 32'h2100, 6, 0);
    wait_bits(6'h20, 32'h2);
    cmp_copy("R4", 32'h100, 32'h2100, 6);
    rwr(6'h20, 32'h2);

    // R10 maximum count
    fill(0, 32'h800, 2048);
    start(2, 0, 32'h2000, 32'h1FFF, 0);
    wait_bits(6'h20, 32'h4);
    cmp_copy("R10", 0, 32'h2000, 32'h1FFF);
    chk("R10 no write past 2048 words", 32'(oob), 0);
    rrd(ca(2, 0), d); chk("R10 source after max", d, 32'h1FFF);
    rwr(6'h20, 32'h4);

    // R6 fail countdown of 1: abort on first visit
    fill(32'h80, 32'h880, 8);
    start(3, 32'h200, 32'h2200, 16, 1);
    wait_bits(6'h21, 32'h8);
    rrd(6'h20, d); chk("R6 no completion on abort", d, 0);
    rrd(ca(3, 2), d); chk("R6 count unchanged on abort", d, 16);
    rrd(ca(3, 3), d); chk("R6 run cleared on abort", d, 0);
    chk("R6 destination untouched", mem[32'h880], 32'hA5A5_0000);
    chk("R9 irq from error flag", 32'(irq), 1);
    rwr(6'h21, 32'h7);
    rrd(6'h21, d); chk("R9 other bits leave error flag", d, 32'h8);
    rwr(6'h21, 32'h8);
    rrd(6'h21, d); chk("R9 error flag cleared", d, 0);

    // R6 R3 fail countdown of 3: two bursts then abort
    start(0, 0, 32'h2000, 32'h1800, 3);
    wait_bits(6'h21, 32'h1);
    rrd(ca(0, 2), d); chk("R3 two bursts removed from count", d, 32'h800);
    rrd(ca(0, 0), d); chk("R3 source after two bursts", d, 32'h1000);
    rrd(ca(0, 4), d); chk("R6 countdown exhausted", d, 0);
    rrd(6'h20, d); chk("R6 completion stays clear", d, 0);
    rwr(6'h21, 32'h1);

    // R7 R8 stop during a burst
    start(1, 0, 32'h2000, 32'h1FFF, 0);
    repeat (50) @(negedge clk);
    rrd(ca(1, 3), d); chk("R7 running reads busy", d, 32'h8000_0000);
    rwr(ca(1, 0), 32'h300);
    rrd(ca(1, 0), d); chk("R8 source write ignored", d, 0);
    rwr(ca(1, 2), 32'd5);
    rrd(ca(1, 2), d); chk("R8 count write ignored", d, 32'h1FFF);
    rwr(ca(1, 3), 32'h0);
    rrd(ca(1, 3), d); chk("R7 stop reads idle", d, 0);
    repeat (1500) @(negedge clk);
    rrd(ca(1, 2), d); chk("R7 current burst finished", d, 32'h17FF);
    rrd(6'h20, d); chk("R7 no completion after stop", d, 0);

    // R2 two channels share bursts in rotation
    fill(0, 32'h800, 2048);
    n_own = 0;
    log_on = 1'b1;
    start(0, 0, 32'h2000, 32'h1000, 0);
    start(2, 32'h1000, 32'h3000, 32'h1000, 0);
    wait_bits(6'h20, 32'h5);
    log_on = 1'b0;
    chk("R2 burst owner changes", 32'(n_own), 4);
    chk("R2 alternation 0-1", 32'(own_log[0] != own_log[1]), 1);
    chk("R2 alternation 1-2", 32'(own_log[1] != own_log[2]), 1);
    chk("R2 alternation 2-3", 32'(own_log[2] != own_log[3]), 1);
    rwr(6'h20, 32'h5);

    // R3 R4 R5 random copies
    for (int t = 0; t < 12; t++) begin
      int ch, cnt, src, dst;
      ch  = $urandom_range(0, 3);
      cnt = $urandom_range(1, 32'h1000);
      src = 4 * $urandom_range(0, 32'h400);
      dst = 32'h2000 + 4 * $urandom_range(0, 32'h400);
      fill(src / 4, dst / 4, words_of(cnt) + 1);
      start(ch, src, dst, cnt, 0);
      wait_bits(6'h20, 32'(1) << ch);
      cmp_copy("R3 random", src, dst, cnt);
      rrd(ca(ch, 2), d); chk("R5 random count drained", d, 0);
      rrd(ca(ch, 1), d); chk("R3 random destination", d, 32'(dst + cnt));
      rwr(6'h20, 32'hF);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule